// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block takes an asynchronous serial line that idles high and recovers each data word sent on it. At run time the framing can be set to 5, 6, 7 or 8 data bits, with no parity, even parity or odd parity, and with one or two stop bits. A divisor input sets the bit time as a number of clock cycles. The line passes through a two-flop synchronizer. A low level on an idle line starts a frame. The start bit is checked again half a bit later, so a short glitch does not start a frame. After that, every later bit is sampled once per divisor period, near the middle of the bit.

When the last stop bit has been sampled, the word is stored right-aligned in an output register and a ready flag rises. A parity-error flag and a framing-error flag describe that same word. A one-cycle read strobe takes the word and clears the ready flag. If a second word completes before the first one is read, the new word replaces the old one and an overrun flag is set. Software or a downstream engine polls the ready flag and strobes the read when it takes the word.

Top module: `uart_frame_rx`

## Requirements
- R1: When the synchronized line is low while the receiver is idle, a frame begins. The start bit is sampled again `cfg_div/2` cycles later. Each following bit is sampled once every `cfg_div` cycles. `cfg_div` must be at least 8 and must stay constant during a frame.
- R2: A low pulse that is high again when the start bit is sampled again is ignored. It produces no word, leaves `rx_ready` low, and the next valid frame is received correctly.
- R3: Data bits arrive least significant bit first. `cfg_data_bits` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. The word appears on `rx_data` right-aligned, and the unused upper bits are zero.
- R4: When `cfg_parity_en` is 1, one parity bit follows the data. With `cfg_parity_odd` = 0, the data bits and the parity bit together must hold an even number of ones. With `cfg_parity_odd` = 1, they must hold an odd number. A mismatch sets `rx_parity_err` for that word. With parity disabled, `rx_parity_err` is 0.
- R5: `cfg_two_stop` selects one stop bit (0) or two stop bits (1). If any sampled stop bit is low, `rx_frame_err` is set for that word.
- R6: After the final stop bit has been sampled, `rx_ready` rises. `rx_data` and the error flags then hold their values until the next word completes.
- R7: A high `rd_en` while `rx_ready` is set clears `rx_ready` and `rx_overrun` on the next cycle. A high `rd_en` while `rx_ready` is low has no effect on any output.
- R8: If a word completes while `rx_ready` is set and `rd_en` is low, `rx_overrun` rises and the new word replaces the stored one.
- R9: If `rd_en` is high in the same cycle that a word completes, the new word is stored, `rx_ready` stays high and `rx_overrun` stays low.
- R10: After reset, `rx_ready`, `rx_overrun`, `rx_parity_err`, `rx_frame_err` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_serial | input | 1 | Asynchronous serial line, idles high |
| cfg_div | input | DIV_W | Clock cycles per bit (at least 8) |
| cfg_data_bits | input | 2 | Data bit count code: 0..3 selects 5..8 bits |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rd_en | input | 1 | Read strobe, takes the word and clears ready |
| rx_data | output | 8 | Last received word, right-aligned |
| rx_ready | output | 1 | An unread word is present |
| rx_parity_err | output | 1 | Parity mismatch on the stored word |
| rx_frame_err | output | 1 | Low stop bit on the stored word |
| rx_overrun | output | 1 | A word was replaced before it was read |

## Verification
Two events can fall in the same cycle: a word finishing and a read strobe. Together they decide whether the result is a clean hand-over or an overrun. The bench counts the cycles from the start edge through the synchronizer, the half-bit wait and each bit period. With a first word still unread, it raises `rd_en` exactly in the cycle the second word completes. The pass condition is: `rx_ready` still high, `rx_data` holding the second word, and `rx_overrun` low. A separate run sends the same two words with no read and expects the overrun flag.

// File: rtl/uart_rx_pkg.sv
// Package: types and constants shared by the receiver modules.
// Assumes: words are at most 8 bits; the data bit count code is 2 bits wide.
package uart_rx_pkg;
    localparam int WORD_W   = 8;
    localparam int BITS_W   = 2;
    localparam int IDX_W    = 3;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
// Module: two-flop synchronizer for the asynchronous serial input.
// Assumes: the line idles high, so both flops reset to 1.
module uart_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;
    logic sync_q;

    // Shift the line through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/uart_rx_baud.sv
// Module: down-counter that times bit sampling points.
// Assumes: div is at least 8 and stays constant while a frame is in progress.
module uart_rx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             load_half,
    input  logic             load_full,
    input  logic             active,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Load half or full bit periods, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_half) begin
            cnt_q <= (div >> 1) - DIV_W'(1);
        end else if (load_full) begin
            cnt_q <= div - DIV_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    // A sample point is due when the count is exhausted during a frame.
    assign tick = active && (cnt_q == '0);
endmodule

// File: rtl/uart_rx_frame.sv
// Module: frame sequencer. Checks the start bit, shifts in the data bits, checks
// parity and the stop bits, and pulses done with the aligned word and the error bits.
// Assumes: rx_s is already synchronized; the configuration is captured at the start edge.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [BITS_W-1:0] cfg_data_bits,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    output logic              done,
    output logic [WORD_W-1:0] word,
    output logic              perr,
    output logic              ferr
);
    rx_state_t          state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [WORD_W-1:0]  shift_q;
    logic [BITS_W-1:0]  nbits_q;
    logic               pen_q, podd_q, two_q, stop2_q;
    logic               pacc_q, perr_q, ferr_q, done_q;
    logic               tick, load_half, load_full, active;
    logic [IDX_W-1:0]   last_idx;
    logic [IDX_W-1:0]   shamt;

    assign active    = (state_q != RX_IDLE);
    assign load_half = (state_q == RX_IDLE) && !rx_s;
    assign last_idx  = IDX_W'(MIN_BITS - 1) + {1'b0, nbits_q};
    assign shamt     = IDX_W'(WORD_W - MIN_BITS) - {1'b0, nbits_q};

    // Reload a full period at every sample except the one that ends the frame.
    always_comb begin
        load_full = 1'b0;
        if (tick) begin
            if (state_q == RX_STOP)
                load_full = two_q && !stop2_q;
            else if (state_q == RX_START)
                load_full = !rx_s;
            else
                load_full = 1'b1;
        end
    end

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (cfg_div),
        .load_half (load_half),
        .load_full (load_full),
        .active    (active),
        .tick      (tick)
    );

    // Step through the frame fields at each sample point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
            shift_q <= '0;
            nbits_q <= '0;
            pen_q   <= 1'b0;
            podd_q  <= 1'b0;
            two_q   <= 1'b0;
            stop2_q <= 1'b0;
            pacc_q  <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (!rx_s) begin
                        state_q <= RX_START;
                        idx_q   <= '0;
                        shift_q <= '0;
                        nbits_q <= cfg_data_bits;
                        pen_q   <= cfg_parity_en;
                        podd_q  <= cfg_parity_odd;
                        two_q   <= cfg_two_stop;
                        stop2_q <= 1'b0;
                        pacc_q  <= 1'b0;
                        perr_q  <= 1'b0;
                        ferr_q  <= 1'b0;
                    end
                end
                RX_START: begin
                    if (tick) state_q <= rx_s ? RX_IDLE : RX_DATA;
                end
                RX_DATA: begin
                    if (tick) begin
                        shift_q <= {rx_s, shift_q[WORD_W-1:1]};
                        pacc_q  <= pacc_q ^ rx_s;
                        idx_q   <= idx_q + IDX_W'(1);
                        if (idx_q == last_idx) state_q <= pen_q ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    if (tick) begin
                        perr_q  <= (rx_s != (pacc_q ^ podd_q));
                        state_q <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (!rx_s) ferr_q <= 1'b1;
                        if (two_q && !stop2_q) begin
                            stop2_q <= 1'b1;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= RX_IDLE;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign word = shift_q >> shamt;
    assign perr = perr_q;
    assign ferr = ferr_q;
endmodule

// File: rtl/uart_rx_hold.sv
// Module: output holding register with a ready flag that a read clears, plus overrun.
// Assumes: done is a one-cycle pulse, and word/perr/ferr are valid while it is high.
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [WORD_W-1:0] word,
    input  logic              perr,
    input  logic              ferr,
    input  logic              rd_en,
    output logic [WORD_W-1:0] data,
    output logic              ready,
    output logic              parity_err,
    output logic              frame_err,
    output logic              overrun
);
    // Capture completed words; a read frees the slot in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data       <= '0;
            ready      <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end else if (done) begin
            data       <= word;
            parity_err <= perr;
            frame_err  <= ferr;
            ready      <= 1'b1;
            overrun    <= ready && !rd_en;
        end else if (rd_en && ready) begin
            ready   <= 1'b0;
            overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_frame_rx.sv
// Module: top of the configurable UART frame receiver.
// Assumes: the configuration and cfg_div change only while the line is idle.
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_serial,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_data_bits,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    input  logic              rd_en,
    output logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              rx_parity_err,
    output logic              rx_frame_err,
    output logic              rx_overrun
);
    logic              w_rx_s;
    logic              w_done;
    logic [WORD_W-1:0] w_word;
    logic              w_perr, w_ferr;

    uart_rx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_serial),
        .dout  (w_rx_s)
    );

    uart_rx_frame #(.DIV_W(DIV_W)) u_frame (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_s           (w_rx_s),
        .cfg_div        (cfg_div),
        .cfg_data_bits  (cfg_data_bits),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_parity_odd (cfg_parity_odd),
        .cfg_two_stop   (cfg_two_stop),
        .done           (w_done),
        .word           (w_word),
        .perr           (w_perr),
        .ferr           (w_ferr)
    );

    uart_rx_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (w_done),
        .word       (w_word),
        .perr       (w_perr),
        .ferr       (w_ferr),
        .rd_en      (rd_en),
        .data       (rx_data),
        .ready      (rx_ready),
        .parity_err (rx_parity_err),
        .frame_err  (rx_frame_err),
        .overrun    (rx_overrun)
    );
endmodule

// File: rtl/uart_rx_checker.sv
// Module: assertions for the receiver's output handshake, attached with bind.
// Assumes: done is the sequencer's completion pulse inside the top module.
module uart_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       done,
    input logic       rx_ready,
    input logic       rx_overrun,
    input logic [7:0] rx_data
);
    p_ready_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_ready);

    p_data_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !done) |=> $stable(rx_data));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rd_en && !done) |=> (!rx_ready && !rx_overrun));

    p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_en && done) |=> rx_overrun);

    p_no_overrun_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && done) |=> (rx_ready && !rx_overrun));

    p_overrun_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(done));

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind uart_frame_rx uart_rx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .done       (w_done),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun),
    .rx_data    (rx_data)
);

// File: tb/uart_frame_rx_tb.sv
// Bench: directed corner cases plus seeded random frames, compared with expected values from functions.
module uart_frame_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_serial = 1'b1;
    logic [DIV_W-1:0] cfg_div = 16'd8;
    logic [1:0]       cfg_data_bits = 2'd3;
    logic             cfg_parity_en = 1'b0;
    logic             cfg_parity_odd = 1'b0;
    logic             cfg_two_stop = 1'b0;
    logic             rd_en = 1'b0;
    logic [7:0]       rx_data;
    logic             rx_ready, rx_parity_err, rx_frame_err, rx_overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_frame_rx #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial), .cfg_div(cfg_div),
        .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop), .rd_en(rd_en),
        .rx_data(rx_data), .rx_ready(rx_ready), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun)
    );

    function automatic logic [7:0] exp_word(input logic [7:0] d, input int code);
        return d & 8'((1 << (code + 5)) - 1);
    endfunction

    function automatic int frame_bits(input int code, input bit pen, input bit two);
        return code + 5 + int'(pen) + (two ? 2 : 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx_serial = b;
        repeat (int'(cfg_div)) @(posedge clk);
        #1;
    endtask

    // Sends one frame with the current configuration; can corrupt parity or the last stop bit.
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        logic [7:0] w;
        w = exp_word(d, int'(cfg_data_bits));
        @(posedge clk); #1;
        drive_bit(1'b0);
        for (int i = 0; i < int'(cfg_data_bits) + 5; i++) drive_bit(w[i]);
        if (cfg_parity_en) drive_bit((^w) ^ cfg_parity_odd ^ bad_par);
        if (cfg_two_stop) drive_bit(1'b1);
        drive_bit(!bad_stop);
        rx_serial = 1'b1;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic do_read();
        @(posedge clk); #1 rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic set_cfg(input int div, input int code, input bit pen, input bit odd, input bit two);
        @(negedge clk);
        cfg_div = DIV_W'(div);
        cfg_data_bits = 2'(code);
        cfg_parity_en = pen;
        cfg_parity_odd = odd;
        cfg_two_stop = two;
    endtask

    // Sends one frame, checks the stored word and its flags, then reads it and checks that ready clears.
    task automatic frame_and_check(input logic [7:0] d, input bit bp, input bit bs, input string tag);
        logic [7:0] e;
        e = exp_word(d, int'(cfg_data_bits));
        send_frame(d, bp, bs);
        @(negedge clk);
        check(rx_ready === 1'b1, {tag, " R6 ready"}, int'(rx_ready), 1);
        check(rx_data === e, {tag, " R3 data"}, int'(rx_data), int'(e));
        check(rx_parity_err === (bp && cfg_parity_en), {tag, " R4 parity"},
              int'(rx_parity_err), int'(bp && cfg_parity_en));
        check(rx_frame_err === bs, {tag, " R5 stop"}, int'(rx_frame_err), int'(bs));
        do_read();
        @(negedge clk);
        check(rx_ready === 1'b0, {tag, " R7 cleared"}, int'(rx_ready), 0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: state after reset
        check(rx_ready === 1'b0 && rx_overrun === 1'b0 && rx_parity_err === 1'b0 &&
              rx_frame_err === 1'b0 && rx_data === 8'h00, "R10 reset",
              int'({rx_ready, rx_overrun, rx_parity_err, rx_frame_err}), 0);

        // R1 R3: 8N1 basic frame
        set_cfg(8, 3, 0, 0, 0);
        frame_and_check(8'hA5, 0, 0, "R1 8N1");
        // R3: 5-bit word, upper bits masked off
        set_cfg(10, 0, 0, 0, 0);
        frame_and_check(8'hFB, 0, 0, "R3 5bit");
        // R4: even parity, good then bad
        set_cfg(8, 2, 1, 0, 0);
        frame_and_check(8'h35, 0, 0, "R4 even ok");
        frame_and_check(8'h35, 1, 0, "R4 even bad");
        // R4: odd parity, good then bad
        set_cfg(16, 1, 1, 1, 1);
        frame_and_check(8'h2C, 0, 0, "R4 odd ok");
        frame_and_check(8'h2C, 1, 0, "R4 odd bad");
        // R5: two stop bits with the second one low
        set_cfg(12, 3, 0, 0, 1);
        frame_and_check(8'h81, 0, 1, "R5 two stop");

        // R2: short low glitch
        set_cfg(16, 3, 0, 0, 0);
        @(posedge clk); #1 rx_serial = 1'b0;
        repeat (2) @(posedge clk);
        #1 rx_serial = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(rx_ready === 1'b0, "R2 glitch ignored", int'(rx_ready), 0);
        frame_and_check(8'h5A, 0, 0, "R2 after glitch");

        // R7: a read while not ready changes nothing
        do_read();
        @(negedge clk);
        check(rx_ready === 1'b0 && rx_data === 8'h5A && rx_overrun === 1'b0,
              "R7 idle read", int'(rx_data), 'h5A);

        // R8: overrun when the second word arrives unread
        set_cfg(8, 3, 0, 0, 0);
        send_frame(8'h11, 0, 0);
        send_frame(8'h22, 0, 0);
        @(negedge clk);
        check(rx_overrun === 1'b1, "R8 overrun flag", int'(rx_overrun), 1);
        check(rx_data === 8'h22, "R8 data replaced", int'(rx_data), 'h22);
        do_read();
        @(negedge clk);
        check(rx_overrun === 1'b0 && rx_ready === 1'b0, "R7 read clears overrun",
              int'({rx_ready, rx_overrun}), 0);

        // R9: read strobe in the cycle the second word completes
        send_frame(8'h33, 0, 0);
        fork
            send_frame(8'h44, 0, 0);
            begin
                @(posedge clk);
                repeat (3 + 4 + frame_bits(3, 0, 0) * 8) @(posedge clk);
                #1 rd_en = 1'b1;
                @(posedge clk); #1 rd_en = 1'b0;
            end
        join
        @(negedge clk);
        check(rx_ready === 1'b1 && rx_overrun === 1'b0, "R9 collision flags",
              int'({rx_ready, rx_overrun}), 2);
        check(rx_data === 8'h44, "R9 collision data", int'(rx_data), 'h44);
        do_read();

        // R1 R3 R4 R5: seeded random frames
        for (int k = 0; k < 40; k++) begin
            int divs[4] = '{8, 10, 12, 16};
            set_cfg(divs[$urandom_range(0, 3)], int'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)));
            frame_and_check(8'($urandom), ($urandom_range(0, 4) == 0),
                            ($urandom_range(0, 4) == 0), "R1 random");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule